// File: doc/BRIEF.md
# Data-Dependent LSB-First Successive-Approximation Controller

This block is the digital search engine of a charge-redistribution ADC. The resolution can be set anywhere from 5 to 10 bits. A conventional controller always starts at mid-scale and spends one comparison per bit. This controller starts each conversion at the code it produced for the previous sample. It first probes small offsets around that code, starting with one LSB, and doubles the offset until the comparator changes its answer or the code range ends. It then runs an ordinary binary search inside the bracket it found. A slowly moving input therefore settles in a few comparisons, and the number of comparisons used is reported with every result.

The analog side is outside the block. The DAC takes `dac_code_o`. The comparator returns `cmp_i` in the same cycle, high when the sampled input is at or above the DAC level. A one-cycle `sample_i` strobe starts a conversion. A one-cycle `done_o` pulse marks the end, with the code and the comparison count.

Top module: `lsbf_sar_ctrl`

## Requirements
- R1: The effective resolution N is `res_i` clamped to the range 5..10. The DAC code never exceeds 2^N−1 and uses only the low N bits. An input above full scale converts to 2^N−1.
- R2: The first probe of a conversion equals the final code of the previous conversion.
- R3: After reset, or when the effective resolution differs from that of the previous conversion, the first probe is mid-scale, 2^(N−1).
- R4: Let p be the first probe. If the comparator answers 1 at p, the next probes are p+1, p+3, p+7, … (offsets 2^k−1). If it answers 0, the next probes are p−1, p−3, p−7, …. Each probe is clamped to 0 or 2^N−1. The walk ends when the comparator answer flips. It also ends on a probe at a bound where the answer keeps its direction, and the result is then that bound.
- R5: After the flip, each probe is floor((lo+hi)/2). Here lo is the highest probed code that answered 1 and hi is the lowest that answered 0. The search stops when hi−lo = 1, and the result is lo. For an input value T, the result is therefore min(T, 2^N−1).
- R6: `cycles_o` equals the number of comparisons (DAC probes) used by the conversion. It is never more than 2N.
- R7: `done_o` is high for exactly one cycle, the cycle after the last probe. `code_o` and `cycles_o` change only together with `done_o` and hold their values in between.
- R8: A `sample_i` strobe during a conversion is ignored. The probe sequence and the result are unchanged.
- R9: During reset, `done_o`, `code_o`, `cycles_o` and `dac_code_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_i | input | 1 | One-cycle conversion start strobe |
| cmp_i | input | 1 | Comparator: 1 when input is at or above the DAC code |
| res_i | input | 4 | Requested resolution in bits, clamped to 5..10 |
| dac_code_o | output | 10 | Code driven to the DAC |
| done_o | output | 1 | One-cycle end-of-conversion pulse |
| code_o | output | 10 | Final code, held until the next result |
| cycles_o | output | 5 | Comparisons used by the last conversion |

## Verification
The assertions check four properties on every cycle:
- the probe stays inside the N-bit range;
- during the binary phase the probe lies strictly inside its bracket;
- the comparison count is within 2N, and a resolution change restarts at mid-scale;
- `done_o` is a single-cycle pulse, and the outputs hold between pulses.

The bench's scenarios cover what the assertions cannot see. They compare the exact probe order against a behavioural model: the start from the previous code, the widening walk in both directions, and saturation at both bounds. The scenarios also confirm that a strobe during a conversion is ignored and that an out-of-range resolution is clamped.

// File: rtl/lsbf_sar_pkg.sv
package lsbf_sar_pkg;
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_FIRST = 3'd1,
    S_UP    = 3'd2,
    S_DN    = 3'd3,
    S_BIN   = 3'd4
  } sar_st_t;
endpackage

// File: rtl/lsbf_sar_range.sv
module lsbf_sar_range #(
  parameter int MAXB = 10,
  parameter int MINB = 5,
  parameter int RW   = 4
) (
  input  logic [RW-1:0]   res_i,
  output logic [RW-1:0]   res_o,
  output logic [MAXB-1:0] maxc_o,
  output logic [MAXB-1:0] midc_o
);
  localparam int WB = MAXB + 2;

  logic [WB-1:0] full_w;
  logic [WB-1:0] half_w;

  always_comb begin
    if (res_i < RW'(MINB))      res_o = RW'(MINB);
    else if (res_i > RW'(MAXB)) res_o = RW'(MAXB);
    else                        res_o = res_i;
    full_w = (WB'(1) << res_o) - WB'(1);
    half_w = WB'(1) << (res_o - RW'(1));
    maxc_o = full_w[MAXB-1:0];
    midc_o = half_w[MAXB-1:0];
  end
endmodule

// File: rtl/lsbf_sar_fsm.sv
module lsbf_sar_fsm
  import lsbf_sar_pkg::*;
#(
  parameter int MAXB = 10,
  parameter int RW   = 4,
  parameter int CW   = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            cmp_i,
  input  logic [RW-1:0]   res_i,
  input  logic [MAXB-1:0] maxc_i,
  input  logic [MAXB-1:0] midc_i,
  output logic [MAXB-1:0] dac_o,
  output logic            fin_o,
  output logic [MAXB-1:0] fin_code_o,
  output logic [CW-1:0]   fin_cnt_o
);
  localparam int WB = MAXB + 2;

  sar_st_t       st_q, st_d;
  logic [MAXB-1:0] probe_q, probe_d, lo_q, lo_d, hi_q, hi_d, prev_q, prev_d;
  logic [WB-1:0]   step_q, step_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic [RW-1:0]   res_q, res_d;
  logic [WB-1:0]   up_try, dn_dist;
  logic [MAXB-1:0] nlo, nhi;

  function automatic logic [MAXB-1:0] mid_of(input logic [MAXB-1:0] a,
                                              input logic [MAXB-1:0] b);
    logic [WB-1:0] s;
    s = {2'b00, a} + {2'b00, b};
    return s[MAXB:1];
  endfunction

  always_comb begin
    st_d = st_q;  probe_d = probe_q; lo_d = lo_q; hi_d = hi_q;
    step_d = step_q; cnt_d = cnt_q; prev_d = prev_q; res_d = res_q;
    fin_o = 1'b0; fin_code_o = lo_q;
    up_try  = {2'b00, probe_q} + (step_q << 1);
    dn_dist = step_q << 1;
    nlo = cmp_i ? probe_q : lo_q;
    nhi = cmp_i ? hi_q : probe_q;
    if (st_q != S_IDLE) cnt_d = cnt_q + CW'(1);
    case (st_q)
      S_IDLE: begin
        if (start_i) begin
          st_d    = S_FIRST;
          cnt_d   = '0;
          res_d   = res_i;
          probe_d = (res_i != res_q) ? midc_i : prev_q;
        end
      end
      S_FIRST: begin
        step_d = WB'(1);
        if (cmp_i) begin
          lo_d = probe_q;
          if (probe_q == maxc_i) begin fin_o = 1'b1; fin_code_o = probe_q; end
          else begin st_d = S_UP; probe_d = probe_q + MAXB'(1); end
        end else begin
          hi_d = probe_q;
          if (probe_q == '0) begin fin_o = 1'b1; fin_code_o = '0; end
          else begin st_d = S_DN; probe_d = probe_q - MAXB'(1); end
        end
      end
      S_UP: begin
        if (cmp_i) begin
          lo_d = probe_q;
          if (probe_q == maxc_i) begin fin_o = 1'b1; fin_code_o = probe_q; end
          else begin
            step_d  = step_q << 1;
            probe_d = (up_try > {2'b00, maxc_i}) ? maxc_i : up_try[MAXB-1:0];
          end
        end else begin
          hi_d = probe_q;
          if (probe_q - lo_q == MAXB'(1)) begin fin_o = 1'b1; fin_code_o = lo_q; end
          else begin st_d = S_BIN; probe_d = mid_of(lo_q, probe_q); end
        end
      end
      S_DN: begin
        if (!cmp_i) begin
          hi_d = probe_q;
          if (probe_q == '0) begin fin_o = 1'b1; fin_code_o = '0; end
          else begin
            step_d  = step_q << 1;
            probe_d = ({2'b00, probe_q} <= dn_dist) ? '0 : probe_q - dn_dist[MAXB-1:0];
          end
        end else begin
          lo_d = probe_q;
          if (hi_q - probe_q == MAXB'(1)) begin fin_o = 1'b1; fin_code_o = probe_q; end
          else begin st_d = S_BIN; probe_d = mid_of(probe_q, hi_q); end
        end
      end
      S_BIN: begin
        lo_d = nlo;
        hi_d = nhi;
        if (nhi - nlo == MAXB'(1)) begin fin_o = 1'b1; fin_code_o = nlo; end
        else probe_d = mid_of(nlo, nhi);
      end
      default: st_d = S_IDLE;
    endcase
    if (fin_o) begin
      st_d   = S_IDLE;
      prev_d = fin_code_o;
    end
  end

  assign fin_cnt_o = cnt_q + CW'(1);
  assign dac_o     = probe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      probe_q <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
      step_q  <= '0;
      cnt_q   <= '0;
      prev_q  <= MAXB'(1) << (MAXB - 1);
      res_q   <= RW'(MAXB);
    end else begin
      st_q    <= st_d;
      probe_q <= probe_d;
      lo_q    <= lo_d;
      hi_q    <= hi_d;
      step_q  <= step_d;
      cnt_q   <= cnt_d;
      prev_q  <= prev_d;
      res_q   <= res_d;
    end
  end

  AST_PROBE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != S_IDLE) |-> (({2'b00, dac_o} >> res_q) == '0)); // R1
  AST_MID_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_IDLE && start_i && res_i != res_q) |=> (dac_o == $past(midc_i))); // R3
  AST_BRACKET_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_BIN) |-> (lo_q < probe_q && probe_q < hi_q)); // R5
  AST_CYCLE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    fin_o |-> (int'(fin_cnt_o) <= 2 * int'(res_q))); // R6
endmodule

// File: rtl/lsbf_sar_hold.sv
module lsbf_sar_hold #(
  parameter int MAXB = 10,
  parameter int CW   = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fin_i,
  input  logic [MAXB-1:0] code_i,
  input  logic [CW-1:0]   cnt_i,
  output logic            done_o,
  output logic [MAXB-1:0] code_o,
  output logic [CW-1:0]   cycles_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o   <= 1'b0;
      code_o   <= '0;
      cycles_o <= '0;
    end else begin
      done_o <= fin_i;
      if (fin_i) begin
        code_o   <= code_i;
        cycles_o <= cnt_i;
      end
    end
  end
endmodule

// File: rtl/lsbf_sar_ctrl.sv
module lsbf_sar_ctrl #(
  parameter int MAXB = 10,
  parameter int MINB = 5,
  parameter int RW   = $clog2(MAXB + 1),
  parameter int CW   = $clog2(2 * MAXB + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sample_i,
  input  logic            cmp_i,
  input  logic [RW-1:0]   res_i,
  output logic [MAXB-1:0] dac_code_o,
  output logic            done_o,
  output logic [MAXB-1:0] code_o,
  output logic [CW-1:0]   cycles_o
);
  logic [RW-1:0]   res_eff;
  logic [MAXB-1:0] maxc, midc, fin_code;
  logic            fin;
  logic [CW-1:0]   fin_cnt;

  lsbf_sar_range #(.MAXB(MAXB), .MINB(MINB), .RW(RW)) u_range (
    .res_i(res_i), .res_o(res_eff), .maxc_o(maxc), .midc_o(midc));

  lsbf_sar_fsm #(.MAXB(MAXB), .RW(RW), .CW(CW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start_i(sample_i), .cmp_i(cmp_i),
    .res_i(res_eff), .maxc_i(maxc), .midc_i(midc), .dac_o(dac_code_o),
    .fin_o(fin), .fin_code_o(fin_code), .fin_cnt_o(fin_cnt));

  lsbf_sar_hold #(.MAXB(MAXB), .CW(CW)) u_hold (
    .clk(clk), .rst_n(rst_n), .fin_i(fin), .code_i(fin_code), .cnt_i(fin_cnt),
    .done_o(done_o), .code_o(code_o), .cycles_o(cycles_o));

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R7
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(code_o) && $stable(cycles_o))); // R7
endmodule

// File: tb/lsbf_sar_ctrl_tb.sv
module lsbf_sar_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sample_i = 1'b0;
  logic [3:0] res_i = 4'd10;
  logic [9:0] dac;
  logic       done;
  logic [9:0] code;
  logic [4:0] cycles;
  logic       cmp;
  int         tgt = 0;
  int         total = 0;
  int         bad = 0;
  int         mres = 10;
  int         mprev = 512;
  bit         finished = 1'b0;

  always #4 clk = ~clk;
  assign cmp = (int'(dac) <= tgt);

  lsbf_sar_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .sample_i(sample_i), .cmp_i(cmp), .res_i(res_i),
    .dac_code_o(dac), .done_o(done), .code_o(code), .cycles_o(cycles));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model(input int t, input int n, input int st, ref int pq[$], output int r);
    int maxv = (1 << n) - 1;
    int lo = 0, hi = 0, s = 1, p = st;
    pq.push_back(p);
    if (p <= t) begin
      lo = p;
      if (p == maxv) begin r = maxv; return; end
      forever begin
        p = (lo + s > maxv) ? maxv : lo + s;
        pq.push_back(p);
        if (p <= t) begin
          lo = p;
          if (p == maxv) begin r = maxv; return; end
          s = s * 2;
        end else begin hi = p; break; end
      end
    end else begin
      hi = p;
      if (p == 0) begin r = 0; return; end
      forever begin
        p = (hi - s < 0) ? 0 : hi - s;
        pq.push_back(p);
        if (p > t) begin
          hi = p;
          if (p == 0) begin r = 0; return; end
          s = s * 2;
        end else begin lo = p; break; end
      end
    end
    while (hi - lo > 1) begin
      p = (lo + hi) / 2;
      pq.push_back(p);
      if (p <= t) lo = p; else hi = p;
    end
    r = lo;
  endtask

  task automatic convert(input int t, input int req_res, input bit poke, input string tag);
    int q[$];
    int n, st, r, hold_code;
    n  = (req_res < 5) ? 5 : (req_res > 10) ? 10 : req_res;
    st = (n != mres) ? (1 << (n - 1)) : mprev;
    mres = n;
    model(t, n, st, q, r);
    mprev = r;
    res_i = 4'(req_res);
    tgt = t;
    sample_i = 1'b1;
    @(negedge clk);
    sample_i = 1'b0;
    for (int i = 0; i < q.size(); i++) begin
      chk(int'(dac) == q[i], (i == 0) ? "R2/R3 first probe" : "R4/R5 probe", int'(dac), q[i]);
      chk(int'(dac) < (1 << n), "R1 probe range", int'(dac), (1 << n) - 1);
      chk(done == 1'b0, "R7 no early done", int'(done), 0);
      if (poke && i == 0) sample_i = 1'b1;  // R8 strobe mid-conversion
      @(negedge clk);
      sample_i = 1'b0;
    end
    chk(done == 1'b1, {"R7 done ", tag}, int'(done), 1);
    chk(int'(code) == r, {"R5 code ", tag}, int'(code), r);
    chk(int'(cycles) == q.size(), {"R6 cycles ", tag}, int'(cycles), q.size());
    chk(q.size() <= 2 * n, "R6 bound", q.size(), 2 * n);
    hold_code = int'(code);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(done == 1'b0, "R7 single pulse", int'(done), 0);
      chk(int'(code) == hold_code, "R7 code held", int'(code), hold_code);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R9 done", int'(done), 0);
    chk(code == '0, "R9 code", int'(code), 0);
    chk(cycles == '0, "R9 cycles", int'(cycles), 0);
    chk(dac == '0, "R9 dac", int'(dac), 0);
    rst_n = 1'b1;
    @(negedge clk);
    convert(512, 10, 1'b0, "R3 mid");
    convert(520, 10, 1'b1, "R8 poke up");
    convert(0, 10, 1'b0, "R4 low bound");
    convert(1022, 10, 1'b0, "R6 worst");
    convert(1023, 10, 1'b0, "R4 top bound");
    convert(2000, 10, 1'b0, "R1 overrange");
    convert(9, 5, 1'b0, "R3 res change");
    convert(40, 5, 1'b0, "R1 sat5");
    convert(7, 3, 1'b0, "R1 clamp low");
    convert(300, 10, 1'b0, "R3 back to 10");
    convert(301, 10, 1'b1, "R2 near");
    convert(290, 10, 1'b0, "R4 down");
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule